// File: doc/BRIEF.md
# Capture Delay Eye-Scan Calibrator

This block finds a capture delay for a wide, fast ADC data interface. A start pulse sends one configuration request that puts the converter into its PN9 test output and default format. The block then turns on the receive-side PN9 check with sign extension off. It steps a delay tap through every setting. After each tap change it waits a programmable settle time and then asks an external pattern checker for an error verdict. Each verdict is stored in a two-half pass/fail map: the low half holds results for normal clock polarity and the high half holds results for inverted polarity.

Once a sweep ends, the block walks that half of the map one bit per cycle. It keeps the longest unbroken run of passing taps and picks the tap in the middle of that run. A good enough normal-polarity window is accepted at once. Otherwise the sweep is repeated with the polarity inverted, and the better of the two windows wins, with ties going to the inverted one. The chosen tap and polarity stay on the drive outputs. A second configuration request then takes the converter out of test mode into two's complement output, and the receive side turns sign extension on. If neither polarity has any passing tap, the block flags an error. The converter register transport and the PN9 checker sit outside the block. Both are reached through request/done handshakes. TAPS must be a power of two.

Top module: `eye_scan_cal`

## Requirements
- R1: After reset, busy, done, fail, cfg_req, chk_req, chk_en, sign_ext and pol_inv are 0, and tap is 0.
- R2: A start pulse in idle raises cfg_req with cfg_restore=0 (enter test mode). Once cfg_ack arrives, chk_en is 1 and sign_ext is 0 for the whole sweep.
- R3: Every sweep issues one chk_req per tap, with tap going 0,1,…,TAPS-1 in order. The first sweep runs with pol_inv=0.
- R4: With S on settle_cycles, chk_req rises exactly S+1 clock cycles after tap or pol_inv last changed. tap and pol_inv hold still while chk_req is high.
- R5: A tap passes when the checker returns chk_err=0. The block takes the longest run of consecutive passing taps in a sweep, and the earlier run wins when lengths tie. The chosen tap is the run start plus half the run length, rounded down.
- R6: If the normal-polarity run is 3 or longer, the block finishes with pol_inv=0 after exactly TAPS checker requests. No inverted sweep takes place.
- R7: If the normal run is shorter than 3, a second full sweep runs with pol_inv=1, giving 2·TAPS requests in total.
- R8: After an inverted sweep, if the inverted run is at least as long as the normal run, the result is pol_inv=1 with the tap taken from the inverted window. Otherwise pol_inv returns to 0 and tap is the normal-window midpoint.
- R9: If both runs are zero, fail becomes 1 and done stays 0. No restore request is issued, so chk_en stays 1.
- R10: On success, cfg_req rises with cfg_restore=1. After cfg_ack, done is 1, busy is 0, chk_en is 0 and sign_ext is 1.
- R11: A start pulse while busy is ignored. The calibration in progress finishes with the same result and the same request count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse to begin a calibration |
| settle_cycles | input | SETTLE_W | Wait after each tap or polarity change, in cycles |
| cfg_req | output | 1 | Converter configuration request |
| cfg_restore | output | 1 | 0: enter PN9 test and default format; 1: test off and two's complement |
| cfg_ack | input | 1 | Configuration request completed |
| chk_req | output | 1 | Ask the pattern checker for a verdict |
| chk_done | input | 1 | Checker verdict valid |
| chk_err | input | 1 | Checker saw errors at this tap |
| chk_en | output | 1 | Receive-side PN9 check enable |
| sign_ext | output | 1 | Receive-side sign extension enable |
| tap | output | $clog2(TAPS) | Delay tap setting; holds the result after done |
| pol_inv | output | 1 | Capture clock polarity inverted; holds the result after done |
| busy | output | 1 | Calibration in progress |
| done | output | 1 | Calibration succeeded |
| fail | output | 1 | No passing tap in either polarity |

## Verification
The bench aims at the window boundaries. These are runs that touch tap 0 or the last tap, a run of exactly 3 that ends the search early, equal-length runs within one sweep, and equal-length runs across the two polarities. A design with an off-by-one in the run counter would choose the wrong midpoint or skip the early exit. One that used the wrong comparison on ties would choose the later run or the wrong polarity. The bench also checks the exact gap between a tap change and the checker request, the number of requests per calibration, and the all-fail case. These catch a design that samples before settling, sweeps an extra polarity, or still sends the restore request after a failure.

// File: rtl/eye_scan_cal.sv
module eye_scan_cal #(
  parameter int TAPS     = 32,
  parameter int MIN_RUN  = 3,
  parameter int SETTLE_W = 8,
  localparam int TAP_W   = $clog2(TAPS),
  localparam int LEN_W   = TAP_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [SETTLE_W-1:0] settle_cycles,
  output logic                cfg_req,
  output logic                cfg_restore,
  input  logic                cfg_ack,
  output logic                chk_req,
  input  logic                chk_done,
  input  logic                chk_err,
  output logic                chk_en,
  output logic                sign_ext,
  output logic [TAP_W-1:0]    tap,
  output logic                pol_inv,
  output logic                busy,
  output logic                done,
  output logic                fail
);

  typedef enum logic [2:0] {
    S_IDLE, S_PREP, S_SETTLE, S_STAT, S_SEARCH, S_DECIDE, S_FIN
  } state_t;

  state_t              st;
  logic [2*TAPS-1:0]   pf_map;
  logic [SETTLE_W-1:0] wait_cnt;
  logic [TAP_W-1:0]    idx, cur_start, best_start, nrm_tap;
  logic [LEN_W-1:0]    cur_len, best_len, nrm_len;

  assign cfg_req     = (st == S_PREP) || (st == S_FIN);
  assign cfg_restore = (st == S_FIN);
  assign chk_req     = (st == S_STAT);
  assign busy        = (st != S_IDLE);

  wire               bit_pass  = ~pf_map[{pol_inv, idx}];
  wire [LEN_W-1:0]   next_len  = bit_pass ? LEN_W'(cur_len + 1'b1) : '0;
  wire [TAP_W-1:0]   next_start = (bit_pass && cur_len == '0) ? idx : cur_start;
  wire [TAP_W-1:0]   win_tap   = best_start + TAP_W'(best_len >> 1);
  wire               long_enough = best_len >= LEN_W'(MIN_RUN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      pf_map     <= '1;
      wait_cnt   <= '0;
      idx        <= '0;
      cur_start  <= '0;
      cur_len    <= '0;
      best_start <= '0;
      best_len   <= '0;
      nrm_tap    <= '0;
      nrm_len    <= '0;
      tap        <= '0;
      pol_inv    <= 1'b0;
      chk_en     <= 1'b0;
      sign_ext   <= 1'b0;
      done       <= 1'b0;
      fail       <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          pf_map <= '1;
          done   <= 1'b0;
          fail   <= 1'b0;
          st     <= S_PREP;
        end
        S_PREP: if (cfg_ack) begin
          chk_en   <= 1'b1;
          sign_ext <= 1'b0;
          tap      <= '0;
          pol_inv  <= 1'b0;
          wait_cnt <= settle_cycles;
          st       <= S_SETTLE;
        end
        S_SETTLE: begin
          if (wait_cnt == '0) st <= S_STAT;
          else wait_cnt <= wait_cnt - 1'b1;
        end
        S_STAT: if (chk_done) begin
          pf_map[{pol_inv, tap}] <= chk_err;
          if (tap == TAP_W'(TAPS - 1)) begin
            idx        <= '0;
            cur_start  <= '0;
            cur_len    <= '0;
            best_start <= '0;
            best_len   <= '0;
            st         <= S_SEARCH;
          end else begin
            tap      <= tap + 1'b1;
            wait_cnt <= settle_cycles;
            st       <= S_SETTLE;
          end
        end
        S_SEARCH: begin
          cur_len   <= next_len;
          cur_start <= next_start;
          if (next_len > best_len) begin
            best_len   <= next_len;
            best_start <= next_start;
          end
          if (idx == TAP_W'(TAPS - 1)) st <= S_DECIDE;
          else idx <= idx + 1'b1;
        end
        S_DECIDE: begin
          if (!pol_inv) begin
            if (long_enough) begin
              tap <= win_tap;
              st  <= S_FIN;
            end else begin
              nrm_len  <= best_len;
              nrm_tap  <= win_tap;
              pol_inv  <= 1'b1;
              tap      <= '0;
              wait_cnt <= settle_cycles;
              st       <= S_SETTLE;
            end
          end else if (best_len == '0 && nrm_len == '0) begin
            fail <= 1'b1;
            st   <= S_IDLE;
          end else if (best_len >= nrm_len) begin
            tap <= win_tap;
            st  <= S_FIN;
          end else begin
            pol_inv <= 1'b0;
            tap     <= nrm_tap;
            st      <= S_FIN;
          end
        end
        S_FIN: if (cfg_ack) begin
          chk_en   <= 1'b0;
          sign_ext <= 1'b1;
          done     <= 1'b1;
          st       <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_one_handshake_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_req && chk_req));

  assert_tap_still_R4: assert property (@(posedge clk) disable iff (!rst_n)
    chk_req |-> $stable(tap) && $stable(pol_inv));

  assert_check_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
    chk_req |-> chk_en && !sign_ext);

  assert_inv_from_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pol_inv) |-> busy && tap == '0);

  assert_outcome_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));

  assert_restored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !busy && !chk_en && sign_ext);

endmodule

// File: tb/test_eye_scan_cal.sv
module test_eye_scan_cal;
  localparam int TAPS = 32;
  localparam int TW   = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] settle_cycles = 8'd0;
  logic cfg_req, cfg_restore, chk_req, chk_en, sign_ext, pol_inv, busy, done, fail;
  logic cfg_ack = 1'b0, chk_done = 1'b0, chk_err = 1'b0;
  logic [TW-1:0] tap;

  eye_scan_cal i_eye_scan_cal (
    .clk(clk), .rst_n(rst_n), .start(start), .settle_cycles(settle_cycles),
    .cfg_req(cfg_req), .cfg_restore(cfg_restore), .cfg_ack(cfg_ack),
    .chk_req(chk_req), .chk_done(chk_done), .chk_err(chk_err),
    .chk_en(chk_en), .sign_ext(sign_ext), .tap(tap), .pol_inv(pol_inv),
    .busy(busy), .done(done), .fail(fail)
  );

  always #5 clk = ~clk;

  int errors = 0, checks = 0;
  logic [63:0] fmap = '1;
  int nreq, ninv_req, seq_bad, settle_bad, en_bad, n_enter, n_restore;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin : chk_resp
    int lat = 0;
    forever begin
      @(posedge clk);
      if (chk_req && !chk_done) begin
        if (lat == 0) begin
          chk_done <= 1'b1;
          chk_err  <= fmap[{pol_inv, tap}];
          lat = int'($urandom % 3);
        end else lat--;
      end else chk_done <= 1'b0;
    end
  end

  initial begin : cfg_resp
    int lat = 0;
    forever begin
      @(posedge clk);
      if (cfg_req && !cfg_ack) begin
        if (lat == 0) begin
          cfg_ack <= 1'b1;
          lat = int'($urandom % 4);
        end else lat--;
      end else cfg_ack <= 1'b0;
    end
  end

  initial begin : monitor
    logic prev_req = 1'b0, prev_cfg = 1'b0, prev_pol = 1'b0;
    logic [TW-1:0] prev_tap = '0;
    int gap = 0;
    forever begin
      @(negedge clk);
      if (tap != prev_tap || pol_inv != prev_pol) gap = 1;
      else if (gap < 100000) gap++;
      if (chk_req && !prev_req) begin
        nreq++;
        if (pol_inv) ninv_req++;
        if (int'(tap) != (nreq - 1) % TAPS || pol_inv != (nreq > TAPS)) seq_bad++;
        if (nreq != 1 && gap != int'(settle_cycles) + 2) settle_bad++;
      end
      if (chk_req && (!chk_en || sign_ext)) en_bad++;
      if (cfg_req && !prev_cfg) begin
        if (cfg_restore) n_restore++; else n_enter++;
      end
      prev_req = chk_req; prev_cfg = cfg_req;
      prev_tap = tap; prev_pol = pol_inv;
    end
  end

  function automatic void best_run(input logic [31:0] h, output int bs, output int bl);
    int cs = 0, cl = 0;
    bs = 0; bl = 0;
    for (int i = 0; i < 32; i++) begin
      if (!h[i]) begin
        if (cl == 0) cs = i;
        cl++;
        if (cl > bl) begin bl = cl; bs = cs; end
      end else cl = 0;
    end
  endfunction

  task automatic run_cal(input logic [63:0] m, input int settle, input bit poke, input string tag);
    int ns, nl, is, il, e_tap, e_inv, e_req, e_fail, t;
    best_run(m[31:0], ns, nl);
    e_fail = 0; e_inv = 0; e_req = 32; e_tap = ns + nl / 2;
    if (nl < 3) begin
      best_run(m[63:32], is, il);
      e_req = 64;
      if (il == 0 && nl == 0) e_fail = 1;
      else if (il >= nl) begin e_inv = 1; e_tap = is + il / 2; end
    end
    fmap = m;
    settle_cycles = 8'(settle);
    @(negedge clk);
    nreq = 0; ninv_req = 0; seq_bad = 0; settle_bad = 0; en_bad = 0; n_enter = 0; n_restore = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    t = 0;
    while (busy && t < 20000) begin
      @(negedge clk);
      t++;
      if (poke && t == 150) start = 1'b1;
      else start = 1'b0;
    end
    start = 1'b0;
    chk(n_enter == 1, {"R2 enter requests ", tag}, n_enter, 1);
    chk(en_bad == 0, {"R2 check enabled during sweep ", tag}, en_bad, 0);
    chk(seq_bad == 0, {"R3 tap order ", tag}, seq_bad, 0);
    chk(settle_bad == 0, {"R4 settle gap ", tag}, settle_bad, 0);
    if (e_req == 32) chk(nreq == 32 && ninv_req == 0, {"R6 requests ", tag}, nreq, 32);
    else chk(nreq == 64 && ninv_req == 32, {"R7 requests ", tag}, nreq, 64);
    if (poke) chk(nreq == e_req, {"R11 start while busy ", tag}, nreq, e_req);
    if (e_fail) begin
      chk(fail && !done, {"R9 fail flag ", tag}, int'(fail), 1);
      chk(n_restore == 0 && chk_en, {"R9 no restore ", tag}, n_restore, 0);
    end else begin
      chk(int'(tap) == e_tap, {"R5 tap ", tag}, int'(tap), e_tap);
      chk(int'(pol_inv) == e_inv, {"R8 polarity ", tag}, int'(pol_inv), e_inv);
      chk(done && !fail && !busy, {"R10 done ", tag}, int'(done), 1);
      chk(n_restore == 1 && !chk_en && sign_ext, {"R10 restore ", tag}, n_restore, 1);
    end
  endtask

  function automatic logic [31:0] window(input int s, input int l);
    logic [31:0] h = '1;
    for (int i = s; i < s + l && i < 32; i++) h[i] = 1'b0;
    return h;
  endfunction

  initial begin : main
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !fail && !cfg_req && !chk_req && !chk_en && !sign_ext
        && !pol_inv && tap == '0, "R1 reset state", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_cal({32'hFFFF_FFFF, 32'h0000_0000}, 0, 1'b0, "all pass");
    run_cal({window(5, 5), 32'hFFFF_FFFF}, 1, 1'b0, "inverted only");
    run_cal({window(10, 2), window(4, 2)}, 2, 1'b0, "tie across polarity");
    run_cal({window(10, 1), window(4, 2)}, 0, 1'b0, "normal longer");
    run_cal('1, 3, 1'b0, "all fail");
    run_cal({32'hFFFF_FFFF, window(2, 4) & window(20, 4)}, 1, 1'b0, "tie in sweep");
    run_cal({32'h0000_0000, window(29, 3)}, 4, 1'b0, "run of 3 at top");
    run_cal({window(0, 1), window(31, 1)}, 0, 1'b0, "single taps at edges");
    run_cal({32'hFFFF_FFFF, window(8, 12)}, 2, 1'b1, "start while busy");

    for (int r = 0; r < 30; r++) begin
      logic [31:0] lo, hi;
      lo = window(int'($urandom % 32), int'($urandom % 7));
      hi = window(int'($urandom % 32), int'($urandom % 9));
      lo &= ~($urandom & $urandom & $urandom);
      hi &= ~($urandom & $urandom);
      run_cal({hi, lo}, int'($urandom % 6), 1'b0, "random");
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule